// File: doc/BRIEF.md
# Prescaled Seconds Counter with Alarm

This block is the timekeeping core of a real-time clock. It runs directly on a slow oscillator clock. A down-counting divider is loaded from a programmable reload value. Whenever the divider reaches zero it produces a one-cycle time-base tick and reloads. The tick period is therefore reload + 1 oscillator cycles. For example, a reload of 32767 on a 32768 Hz oscillator gives one tick per second.

Each tick advances a seconds counter. Three events can be derived from that tick: a seconds event, a counter wrap event and an alarm match event. Each event sets its own sticky flag. Software clears a flag by writing one to it. A single interrupt line combines every flag whose enable is set.

The divider value is always visible, so software can work out the fraction of the current second. For example, 0.25 s at 32768 Hz corresponds to 8192 elapsed cycles since the last reload. Software sets the reload value, the counter, the alarm value and the control bits through a write-only register port.

Top module: `secs_rtc`

## Requirements
- R1: While reset is asserted, the divider holds the reset reload value (32767 by default), and the counter, flags, enables and interrupt are all zero.
- R2: The divider falls by one on each clock. In the cycle where the divider is zero, `tick` is high and the next edge reloads the divider from the reload register, so one period is reload + 1 cycles; a reload of 0 ticks on every cycle.
- R3: A write to address 0 stores `wr_data[19:0]` as the reload value and also restarts the divider at that value on the same edge, even in a cycle where `tick` is high.
- R4: The counter rises by one on each tick. A write to address 1 loads `wr_data` into the counter on the next edge, and it overrides a tick in the same cycle.
- R5: Every tick sets flag bit 0, the seconds flag.
- R6: A tick that occurs while the counter is all ones wraps the counter to zero and sets flag bit 1, the overflow flag.
- R7: A write to address 2 sets the alarm value. Flag bit 2, the alarm flag, is set by a tick whose incremented counter value equals the alarm value.
- R8: A write to address 3 does two things. It replaces the enables with `wr_data[2:0]`, one enable per flag bit. It also clears every flag whose bit in `wr_data[10:8]` is one. If a flag's event occurs in the same cycle as its clear, the flag stays set.
- R9: `irq` is high exactly when some flag and its enable are both set.
- R10: A flag whose enable is clear still latches its event but does not drive `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 reload, 1 counter, 2 alarm, 3 control |
| wr_data | input | 32 | Write data |
| div_q | output | 20 | Current divider value (sub-second remainder) |
| count_q | output | 32 | Seconds counter |
| flags_q | output | 3 | Sticky flags: bit 0 seconds, bit 1 overflow, bit 2 alarm |
| tick | output | 1 | Time-base tick, high while the divider is zero |
| irq | output | 1 | Combined interrupt |

## Verification
Two collisions are provoked on purpose. First, a write-one-to-clear of the flags is issued in exactly the cycle where the divider is at zero. The seconds flag must then survive while the alarm flag is cleared. Second, the alarm value is set to zero and the counter is loaded near its maximum, so the wrapping tick raises the overflow and alarm flags together. The bench expects all three flag bits on the same edge. In the same way, a counter write that lands on a tick cycle must win over the increment.

// File: rtl/secs_rtc.sv
module secs_rtc #(
  parameter int DIV_W    = 20,
  parameter int CNT_W    = 32,
  parameter int RST_LOAD = 32767
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [DIV_W-1:0] div_q,
  output logic [CNT_W-1:0] count_q,
  output logic [2:0]       flags_q,
  output logic             tick,
  output logic             irq
);
  localparam logic [DIV_W-1:0] RST_DIV = DIV_W'(RST_LOAD);

  logic [DIV_W-1:0] load_q;
  logic [CNT_W-1:0] alarm_q;
  logic [2:0]       en_q;
  logic [CNT_W-1:0] cnt_inc;
  logic [2:0]       evt, clr;
  logic             wr_load, wr_cnt, wr_alm, wr_ctl;

  assign wr_load = wr_en && (wr_addr == 2'd0);
  assign wr_cnt  = wr_en && (wr_addr == 2'd1);
  assign wr_alm  = wr_en && (wr_addr == 2'd2);
  assign wr_ctl  = wr_en && (wr_addr == 2'd3);

  assign tick    = (div_q == '0);
  assign cnt_inc = count_q + CNT_W'(1);

  assign evt[0] = tick;
  assign evt[1] = tick && !wr_cnt && (&count_q);
  assign evt[2] = tick && !wr_cnt && (cnt_inc == alarm_q);
  assign clr    = wr_ctl ? wr_data[10:8] : 3'b000;

  assign irq = |(flags_q & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= RST_DIV;
      div_q  <= RST_DIV;
    end else if (wr_load) begin
      load_q <= wr_data[DIV_W-1:0];
      div_q  <= wr_data[DIV_W-1:0];
    end else if (tick) begin
      div_q  <= load_q;
    end else begin
      div_q  <= div_q - DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (wr_cnt) count_q <= wr_data;
    else if (tick)   count_q <= cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= '0;
      en_q    <= '0;
      flags_q <= '0;
    end else begin
      if (wr_alm) alarm_q <= wr_data;
      if (wr_ctl) en_q    <= wr_data[2:0];
      flags_q <= (flags_q & ~clr) | evt;
    end
  end
endmodule

// File: rtl/secs_rtc_chk.sv
module secs_rtc_chk #(
  parameter int DIV_W = 20,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [CNT_W-1:0] wr_data,
  input logic [DIV_W-1:0] div_q,
  input logic [DIV_W-1:0] load_q,
  input logic [CNT_W-1:0] count_q,
  input logic [2:0]       flags_q,
  input logic             tick,
  input logic             irq
);
  logic ld_wr, cnt_wr;
  assign ld_wr  = wr_en && (wr_addr == 2'd0);
  assign cnt_wr = wr_en && (wr_addr == 2'd1);

  // R2
  div_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld_wr) |=> (div_q == DIV_W'($past(div_q) - DIV_W'(1))));

  // R2
  div_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld_wr) |=> (div_q == $past(load_q)));

  // R3
  load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wr |=> (div_q == DIV_W'($past(wr_data))));

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr) |=> (count_q == $past(count_q) + CNT_W'(1)));

  // R5
  sec_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> flags_q[0]);

  // R6
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && (&count_q)) |=> (flags_q[1] && (count_q == '0)));

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q == 3'b000) |-> !irq);
endmodule

bind secs_rtc secs_rtc_chk #(.DIV_W(DIV_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .div_q(div_q), .load_q(load_q), .count_q(count_q), .flags_q(flags_q),
  .tick(tick), .irq(irq)
);

// File: tb/secs_rtc_tb_top.sv
`timescale 1ns/100ps
module secs_rtc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = '0;
  logic [19:0] div_q;
  logic [31:0] count_q;
  logic [2:0]  flags_q;
  logic        tick, irq;

  secs_rtc dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .div_q(div_q), .count_q(count_q), .flags_q(flags_q), .tick(tick), .irq(irq)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int          cyc;
    int          sel;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] obs(input int sel);
    case (sel)
      0:       return {12'd0, div_q};
      1:       return count_q;
      2:       return {29'd0, flags_q};
      3:       return {31'd0, irq};
      default: return {31'd0, tick};
    endcase
  endfunction

  function automatic string nm(input int sel);
    case (sel)
      0:       return "div_q";
      1:       return "count_q";
      2:       return "flags_q";
      3:       return "irq";
      default: return "tick";
    endcase
  endfunction

  task automatic want(input int d, input int sel, input logic [31:0] exp, input string req);
    item_t it;
    it.cyc = cyc + d;
    it.sel = sel;
    it.exp = exp;
    it.req = req;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    #1;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc == cyc) begin
        checks++;
        if (obs(q[i].sel) !== q[i].exp) begin
          errors++;
          $display("FAIL %s: %s actual=%0h expected=%0h (cycle %0d)",
                   q[i].req, nm(q[i].sel), obs(q[i].sel), q[i].exp, cyc);
        end
        q.delete(i);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrap_up();
    if (!done) begin
      done = 1'b1;
      foreach (q[i]) begin
        checks++;
        errors++;
        $display("FAIL %s: %s never sampled, expected=%0h", q[i].req, nm(q[i].sel), q[i].exp);
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    wrap_up();
  end

  initial begin
    idle(2);
    // R1 reset state
    want(0, 0, 32'd32767, "R1");
    want(0, 1, 32'd0, "R1");
    want(0, 2, 32'd0, "R1");
    want(0, 3, 32'd0, "R1");
    idle(1);
    rst_n = 1'b1;
    idle(1);
    want(0, 0, 32'd32766, "R2");
    idle(1);

    // R3 load write restarts divider; R2 period of load+1
    wr(2'd0, 32'd3);
    want(0, 0, 32'd3, "R3");
    want(1, 0, 32'd2, "R2");
    want(3, 0, 32'd0, "R2");
    want(3, 4, 32'd1, "R2");
    want(4, 0, 32'd3, "R2");
    want(4, 1, 32'd1, "R4");
    want(4, 2, 32'd1, "R5");
    want(8, 1, 32'd2, "R2");
    idle(8);

    // R10 flag without enable; R9 irq once enabled
    wr(2'd0, 32'd3);
    want(0, 3, 32'd0, "R10");
    wr(2'd3, 32'h1);
    want(0, 3, 32'd1, "R9");

    // R8 clear then R5 set again on next tick
    wr(2'd3, 32'h101);
    want(0, 2, 32'd0, "R8");
    want(0, 3, 32'd0, "R8");
    want(2, 2, 32'd1, "R5");
    want(2, 1, 32'd3, "R4");
    idle(2);

    // R6 R7 overflow and alarm (alarm value 0) on the same tick
    wr(2'd0, 32'd3);
    wr(2'd1, 32'hFFFF_FFFE);
    wr(2'd3, 32'h707);
    want(0, 2, 32'd0, "R8");
    want(2, 1, 32'hFFFF_FFFF, "R4");
    want(2, 2, 32'd1, "R5");
    want(6, 1, 32'd0, "R6");
    want(6, 2, 32'd7, "R6 R7");
    want(6, 3, 32'd1, "R9");
    idle(6);

    // R7 alarm alone, R10 unenabled seconds flag keeps irq low
    wr(2'd2, 32'd10);
    wr(2'd0, 32'd3);
    wr(2'd1, 32'd8);
    wr(2'd3, 32'h704);
    want(2, 2, 32'd1, "R7");
    want(2, 3, 32'd0, "R10");
    want(6, 2, 32'd5, "R7");
    want(6, 3, 32'd1, "R9");
    idle(6);

    // R8 clear collides with tick: seconds flag survives, alarm flag clears
    wr(2'd0, 32'd2);
    idle(2);
    want(0, 4, 32'd1, "R2");
    wr(2'd3, 32'h704);
    want(0, 2, 32'd1, "R8");
    want(0, 1, 32'd11, "R4");
    want(0, 0, 32'd2, "R2");

    // R4 counter write wins over a simultaneous tick
    idle(2);
    want(0, 4, 32'd1, "R2");
    wr(2'd1, 32'd100);
    want(0, 1, 32'd100, "R4");

    // R2 reload of zero ticks every cycle
    wr(2'd0, 32'd0);
    want(0, 0, 32'd0, "R2");
    want(0, 4, 32'd1, "R2");
    want(3, 1, 32'd103, "R2");
    idle(3);

    // R3 load write while tick is high still restarts at the new value
    wr(2'd0, 32'd5);
    want(0, 0, 32'd5, "R3");
    want(0, 1, 32'd104, "R4");
    idle(2);
    wrap_up();
  end
endmodule